// File: doc/BRIEF.md
# Memory-Mapped SPI Master with Word FIFOs

This block is an SPI bus master driven from a small 32-bit register bus. Software queues outgoing words in a transmit FIFO and then clears a hold bit in the control register. Once that bit is clear, the engine shifts the queued words out on MOSI back to back. It samples MISO in the same frames, or its own MOSI when loopback is on, and it stores one received word per transmitted word in a receive FIFO. Software drains that FIFO by reading the receive data address.

The serial clock runs at a rate fixed by a build parameter: one half period lasts `CLK_DIV` system cycles. Clock polarity, clock phase, bit order and loopback are control bits. The active-low select lines come from a select register. In manual mode they follow that register at all times. Otherwise they follow it only while a word is being shifted and stay high in between. Status reports empty and full for both FIFOs. The transmit-empty flag also waits for the shift engine to go idle.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, control reads 0x100 (hold set, everything else clear), status reads 0x05, the select register reads all ones, every ss_n line is high and sclk is low.
- R2: While control bit 8 (hold) is set, words written to address 0x68 stay queued. No sclk edge occurs, and status bit 2 (TX empty) stays 0.
- R3: With hold clear, enable (bit 1) and master (bit 2) set, queued words are shifted back to back with 2×WORD_W sclk edges each. Each word's received word enters the RX FIFO, and reads of 0x6C pop them in order.
- R4: With control bit 0 (loopback) set, the receive path takes MOSI instead of the miso pin, so the received word equals the sent word. With it clear, the word comes from miso.
- R5: Control bit 9 selects the bit order: 0 sends and assembles most significant bit first, 1 sends least significant bit first.
- R6: Control bit 3 sets the idle sclk level. Control bit 4 selects the capture edge: 0 captures on the leading edge and changes data on the trailing edge, 1 does the reverse.
- R7: With control bit 7 set, ss_n equals the low NUM_SS bits of the select register (0x70) at all times. With it clear, ss_n is all ones except while a word is being shifted, when it equals the register.
- R8: Writing control bit 5 or bit 6 empties the TX or RX FIFO respectively. Neither bit is stored, and the other control bits take the written value.
- R9: A write to a full TX FIFO is dropped. A read of 0x6C while the RX FIFO is empty returns 0 and pops nothing.
- R10: Status bit 2 rises only once the last queued word has been fully shifted and its received word stored, so the status that first shows it also shows the RX FIFO non-empty.
- R11: Status bit 3 flags a full TX FIFO and bit 1 a full RX FIFO. A word completing while the RX FIFO is full is discarded. Status bit 4 (mode fault) always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; pops the RX FIFO at 0x6C |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave selects |

## Verification
The shift engine can complete a word in the same cycle that the bus touches a FIFO it uses. A bus write can push the TX FIFO while the engine pops it. A received word can be pushed while the RX FIFO is already full, and a FIFO reset can arrive while a word is queued. The bench provokes these cases by writing a word right after the RX FIFO fills, by overfilling the held TX FIFO, and by issuing a TX reset with data queued. It judges the outcome purely from the words that come back out of 0x6C, the status flags and the count of sclk edges.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
    localparam logic [7:0] ADDR_CTRL = 8'h60;
    localparam logic [7:0] ADDR_STAT = 8'h64;
    localparam logic [7:0] ADDR_TXD  = 8'h68;
    localparam logic [7:0] ADDR_RXD  = 8'h6C;
    localparam logic [7:0] ADDR_SSEL = 8'h70;

    localparam int B_LOOP   = 0;
    localparam int B_EN     = 1;
    localparam int B_MASTER = 2;
    localparam int B_CPOL   = 3;
    localparam int B_CPHA   = 4;
    localparam int B_TXRST  = 5;
    localparam int B_RXRST  = 6;
    localparam int B_MANSS  = 7;
    localparam int B_HOLD   = 8;
    localparam int B_LSB    = 9;

    typedef struct packed {
        logic lsb;
        logic hold;
        logic man_ss;
        logic cpha;
        logic cpol;
        logic master;
        logic en;
        logic loop;
    } ctrl_t;
endpackage

// File: rtl/sfm_fifo.sv
module sfm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fst_t;

    fst_t s_d, s_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign empty   = (s_q.cnt == '0);
    assign full    = (s_q.cnt == CW'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = mem[s_q.rp];

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d = '0;
        end else begin
            if (do_push)
                s_d.wp = (s_q.wp == AW'(DEPTH - 1)) ? '0 : s_q.wp + AW'(1);
            if (do_pop)
                s_d.rp = (s_q.rp == AW'(DEPTH - 1)) ? '0 : s_q.rp + AW'(1);
            case ({do_push, do_pop})
                2'b10:   s_d.cnt = s_q.cnt + CW'(1);
                2'b01:   s_d.cnt = s_q.cnt - CW'(1);
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[s_q.wp] <= wdata;
    end
endmodule

// File: rtl/sfm_shift.sv
module sfm_shift #(
    parameter int W       = 8,
    parameter int CLK_DIV = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         lsb,
    input  logic         loop,
    input  logic         miso,
    input  logic         tx_avail,
    input  logic [W-1:0] tx_word,
    output logic         tx_pop,
    output logic         rx_push,
    output logic [W-1:0] rx_word,
    output logic         sclk,
    output logic         mosi,
    output logic         busy
);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int EW = $clog2(2 * W);
    localparam int IW = $clog2(W);
    localparam logic [EW-1:0] LAST_EDGE = EW'(2 * W - 1);

    typedef struct packed {
        logic          busy;
        logic          sck;
        logic [DW-1:0] div;
        logic [EW-1:0] edges;
        logic [IW-1:0] idx;
        logic [W-1:0]  txw;
        logic [W-1:0]  rxw;
    } eng_t;

    eng_t e_d, e_q;
    logic bit_in, load;
    logic [W-1:0] sampled;

    assign mosi    = e_q.busy && (lsb ? e_q.txw[e_q.idx] : e_q.txw[IW'(W - 1) - e_q.idx]);
    assign sclk    = cpol ^ e_q.sck;
    assign busy    = e_q.busy;
    assign bit_in  = loop ? mosi : miso;
    assign sampled = lsb ? {bit_in, e_q.rxw[W-1:1]} : {e_q.rxw[W-2:0], bit_in};

    always_comb begin
        e_d     = e_q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        rx_word = e_q.rxw;
        load    = 1'b0;
        if (!e_q.busy) begin
            load = go && tx_avail;
        end else if (e_q.div == DW'(CLK_DIV - 1)) begin
            e_d.div   = '0;
            e_d.edges = e_q.edges + EW'(1);
            e_d.sck   = ~e_q.sck;
            if (!e_q.sck) begin
                // leading edge
                if (!cpha)                 e_d.rxw = sampled;
                else if (e_q.edges != '0)  e_d.idx = e_q.idx + IW'(1);
            end else begin
                // trailing edge
                if (cpha) e_d.rxw = sampled;
                else      e_d.idx = e_q.idx + IW'(1);
                if (e_q.edges == LAST_EDGE) begin
                    rx_push  = 1'b1;
                    rx_word  = cpha ? sampled : e_q.rxw;
                    e_d.busy = 1'b0;
                    load     = go && tx_avail;
                end
            end
        end else begin
            e_d.div = e_q.div + DW'(1);
        end
        if (load) begin
            tx_pop    = 1'b1;
            e_d.busy  = 1'b1;
            e_d.sck   = 1'b0;
            e_d.div   = '0;
            e_d.edges = '0;
            e_d.idx   = '0;
            e_d.txw   = tx_word;
            e_d.rxw   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import sfm_pkg::*;
#(
    parameter int WORD_W     = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int CLK_DIV    = 2,
    parameter int NUM_SS     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_SS-1:0] ss_n
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [NUM_SS-1:0] ss;
    } regs_t;

    regs_t r_d, r_q;
    ctrl_t cfg;
    logic  wr_ctrl, tx_flush, rx_flush, go;
    logic  tx_empty, tx_full, rx_empty, rx_full, stat_tx_empty;
    logic  tx_pop, rx_push, eng_busy, rx_pop;
    logic [WORD_W-1:0] tx_head, rx_head, rx_word;
    logic [31:0] ss_rd;
    logic unused_bits;

    assign cfg         = r_q.ctrl;
    assign wr_ctrl     = bus_wr && (bus_addr == ADDR_CTRL);
    assign tx_flush    = wr_ctrl && bus_wdata[B_TXRST];
    assign rx_flush    = wr_ctrl && bus_wdata[B_RXRST];
    assign go          = cfg.en && cfg.master && !cfg.hold;
    assign rx_pop      = bus_rd && (bus_addr == ADDR_RXD);
    assign unused_bits = ^bus_wdata;

    always_comb begin
        r_d = r_q;
        if (wr_ctrl) begin
            r_d.ctrl.loop   = bus_wdata[B_LOOP];
            r_d.ctrl.en     = bus_wdata[B_EN];
            r_d.ctrl.master = bus_wdata[B_MASTER];
            r_d.ctrl.cpol   = bus_wdata[B_CPOL];
            r_d.ctrl.cpha   = bus_wdata[B_CPHA];
            r_d.ctrl.man_ss = bus_wdata[B_MANSS];
            r_d.ctrl.hold   = bus_wdata[B_HOLD];
            r_d.ctrl.lsb    = bus_wdata[B_LSB];
        end
        if (bus_wr && (bus_addr == ADDR_SSEL))
            r_d.ss = bus_wdata[NUM_SS-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.ctrl.hold <= 1'b1;
            r_q.ss        <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    sfm_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(bus_wr && (bus_addr == ADDR_TXD)), .wdata(bus_wdata[WORD_W-1:0]),
        .pop(tx_pop), .rdata(tx_head), .empty(tx_empty), .full(tx_full)
    );

    sfm_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(rx_push), .wdata(rx_word),
        .pop(rx_pop), .rdata(rx_head), .empty(rx_empty), .full(rx_full)
    );

    sfm_shift #(.W(WORD_W), .CLK_DIV(CLK_DIV)) eng_i (
        .clk(clk), .rst_n(rst_n), .go(go),
        .cpol(cfg.cpol), .cpha(cfg.cpha), .lsb(cfg.lsb), .loop(cfg.loop),
        .miso(miso), .tx_avail(!tx_empty), .tx_word(tx_head),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
        .sclk(sclk), .mosi(mosi), .busy(eng_busy)
    );

    assign stat_tx_empty = tx_empty && !eng_busy;
    assign ss_n = (cfg.man_ss || eng_busy) ? r_q.ss : '1;

    always_comb begin
        ss_rd = '1;
        ss_rd[NUM_SS-1:0] = r_q.ss;
    end

    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = {22'd0, cfg.lsb, cfg.hold, cfg.man_ss, 2'b00,
                                    cfg.cpha, cfg.cpol, cfg.master, cfg.en, cfg.loop};
            ADDR_STAT: bus_rdata = {27'd0, 1'b0, tx_full, stat_tx_empty, rx_full, rx_empty};
            ADDR_RXD:  bus_rdata = rx_empty ? 32'd0 : 32'(rx_head);
            ADDR_SSEL: bus_rdata = ss_rd;
            default:   bus_rdata = 32'd0;
        endcase
    end
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
    parameter int NUM_SS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk,
    input logic [NUM_SS-1:0] ss_n,
    input logic              busy,
    input logic              cpol,
    input logic              hold,
    input logic              man_ss,
    input logic              tx_full,
    input logic              tx_empty,
    input logic              bus_rd,
    input logic [7:0]        bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              rx_empty
);
    // R2
    hold_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !busy) |=> !busy);

    // R6
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cpol));

    // R7
    auto_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!man_ss && !busy) |-> (&ss_n));

    // R11
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full && tx_empty));

    // R9
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'h6C && rx_empty) |-> (bus_rdata == 32'd0));
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.NUM_SS(NUM_SS)) chk_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n), .busy(eng_busy),
    .cpol(cfg.cpol), .hold(cfg.hold), .man_ss(cfg.man_ss),
    .tx_full(tx_full), .tx_empty(stat_tx_empty), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .rx_empty(rx_empty)
);

// File: tb/spi_fifo_master_tb.sv
module spi_fifo_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic        wr = 1'b0, rd = 1'b0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic sclk, mosi;
    logic miso = 1'b0;
    logic [NSS-1:0] ss_n;

    int total = 0, bad = 0;
    int edge_cnt = 0;
    logic [7:0] cap = 8'd0;
    logic cur_cpol = 1'b0, cur_cpha = 1'b0;
    logic prev_sclk = 1'b0, prev_mosi = 1'b0;

    // {miso, lsb, cpha, cpol, loop, word}
    localparam logic [12:0] VECS [7] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5},
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h3C},
        {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h81},
        {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h5E},
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h1D},
        {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h66},
        {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC3}
    };

    spi_fifo_master dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rd(rd), .bus_rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // line monitor: counts sclk edges, captures mosi on the capture edge
    always @(negedge clk) begin
        if (sclk !== prev_sclk) begin
            edge_cnt++;
            if ((sclk != cur_cpol) != cur_cpha) cap = {cap[6:0], prev_mosi};
        end
        prev_sclk = sclk;
        prev_mosi = mosi;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(posedge clk); #1;
        rd = 1'b0;
    endtask

    task automatic wait_done(output logic [31:0] st);
        st = 32'd0;
        for (int i = 0; i < 2000; i++) begin
            bus_read(8'h64, st);
            if (st[2]) break;
        end
    endtask

    task automatic settle_monitor();
        repeat (3) @(negedge clk);
        edge_cnt = 0;
        cap = 8'd0;
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7 - i];
        return r;
    endfunction

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        report();
    end

    initial begin
        logic [31:0] d, st;
        logic [31:0] ctl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(8'h60, d); chk("R1 ctrl", d, 32'h100);
        bus_read(8'h64, d); chk("R1 status", d, 32'h05);
        bus_read(8'h70, d); chk("R1 ssel", d, 32'hFFFF_FFFF);
        chk("R1 ss_n", 32'(ss_n), 32'hF);
        chk("R1 sclk", 32'(sclk), 32'h0);

        // table walk: modes, bit order, loopback (R4 R5 R6)
        for (int v = 0; v < 7; v++) begin
            logic [7:0] w;
            w = VECS[v][7:0];
            cur_cpol = VECS[v][9];
            cur_cpha = VECS[v][10];
            miso = VECS[v][12];
            ctl = 32'h006 | (32'(VECS[v][8])) | (32'(VECS[v][9]) << 3)
                | (32'(VECS[v][10]) << 4) | (32'(VECS[v][11]) << 9);
            bus_write(8'h60, ctl | 32'h100);
            settle_monitor();
            chk("R6 idle level", 32'(sclk), 32'(cur_cpol));
            bus_write(8'h68, 32'(w));
            bus_write(8'h60, ctl);
            wait_done(st);
            bus_read(8'h6C, d);
            chk("R4 rx word", d, VECS[v][8] ? 32'(w) : (VECS[v][12] ? 32'hFF : 32'h00));
            chk("R5 R6 line order", 32'(cap), VECS[v][11] ? 32'(rev8(w)) : 32'(w));
            chk("R6 edge count", edge_cnt, 16);
        end
        cur_cpol = 1'b0; cur_cpha = 1'b0; miso = 1'b0;

        // R2 hold keeps words queued
        bus_write(8'h60, 32'h107);
        settle_monitor();
        bus_write(8'h68, 32'h5A);
        bus_write(8'h68, 32'hC6);
        repeat (60) @(negedge clk);
        chk("R2 no edges", edge_cnt, 0);
        bus_read(8'h64, d); chk("R2 status held", d, 32'h01);
        // R3 release: back to back, in order; R10 tx empty implies rx stored
        bus_write(8'h60, 32'h007);
        wait_done(st);
        chk("R10 rx nonempty at tx empty", 32'(st[0]), 32'h0);
        chk("R3 edges two words", edge_cnt, 32);
        bus_read(8'h6C, d); chk("R3 first word", d, 32'h5A);
        bus_read(8'h6C, d); chk("R3 second word", d, 32'hC6);

        // R9 R11 full TX, full RX, empty read
        bus_write(8'h60, 32'h107);
        for (int k = 0; k < 5; k++) bus_write(8'h68, 32'hA1 + k);
        bus_read(8'h64, d); chk("R11 tx full status", d, 32'h09);
        bus_read(8'h6C, d); chk("R9 empty read", d, 32'h0);
        bus_write(8'h60, 32'h007);
        wait_done(st);
        bus_read(8'h64, d); chk("R11 rx full status", d, 32'h06);
        bus_write(8'h68, 32'h99);
        wait_done(st);
        for (int k = 0; k < 4; k++) begin
            bus_read(8'h6C, d); chk("R9 R11 kept word", d, 32'hA1 + k);
        end
        bus_read(8'h6C, d); chk("R9 R11 dropped words", d, 32'h0);
        bus_read(8'h64, d); chk("R9 status after drain", d, 32'h05);

        // R8 FIFO resets
        bus_write(8'h60, 32'h106);
        settle_monitor();
        bus_write(8'h68, 32'h55);
        bus_read(8'h64, d); chk("R8 tx queued", 32'(d[2]), 32'h0);
        bus_write(8'h60, 32'h126);
        bus_read(8'h60, d); chk("R8 ctrl after tx reset", d, 32'h106);
        bus_read(8'h64, d); chk("R8 tx emptied", d, 32'h05);
        bus_write(8'h60, 32'h007);
        repeat (40) @(negedge clk);
        chk("R8 nothing shifted", edge_cnt, 0);
        bus_write(8'h68, 32'h77);
        wait_done(st);
        bus_write(8'h60, 32'h047);
        bus_read(8'h60, d); chk("R8 ctrl after rx reset", d, 32'h007);
        bus_read(8'h64, d); chk("R8 rx emptied", d, 32'h05);

        // R7 select lines
        bus_write(8'h70, 32'hFFFF_FFFE);
        bus_write(8'h60, 32'h187);
        @(negedge clk);
        chk("R7 manual ss", 32'(ss_n), 32'hE);
        bus_write(8'h60, 32'h107);
        @(negedge clk);
        chk("R7 auto idle", 32'(ss_n), 32'hF);
        bus_write(8'h68, 32'h3F);
        bus_write(8'h60, 32'h007);
        repeat (10) @(negedge clk);
        chk("R7 auto active", 32'(ss_n), 32'hE);
        wait_done(st);
        @(negedge clk);
        chk("R7 auto after", 32'(ss_n), 32'hF);
        bus_read(8'h6C, d); chk("R4 loop word", d, 32'h3F);

        report();
    end
endmodule